// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host reach an external 128K x 8 asynchronous static RAM. The memory has one active-low select, one active-high select, an active-low output enable, an active-low write enable and one byte-wide data bus that carries data in both directions. The host sees a valid/ready request channel and a one-cycle read response. Each accepted request becomes one memory cycle. The strobes of that cycle are timed by counting clock cycles.

Every phase length is the ceiling of a nanosecond minimum divided by the clock-period parameter `CLK_NS`, and it is never less than one cycle. The controller owns the direction of the data bus. The RAM pins are split into a write-data output, a drive-enable output and a read-data input, so the board or pad ring can build the tristate buffer. Between requests both selects are deasserted and the memory stays in standby.

Back-pressure rules: a request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no memory cycle is in progress. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. The response has no back-pressure, so the host must accept `rsp_rdata` in the one cycle that `rsp_valid` is high.

The numbers below use the defaults: 5 ns clock, 70 ns read and write cycles, 25 ns output-enable access, 15 ns bus release, 35 ns write pulse and address-to-end, and 25 ns data setup. With these, a read spends 8 cycles in address phase, 5 in output-enable phase and 1 in capture. A write spends 3 cycles in setup, 7 in pulse and 4 in recovery.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `req_ready`=1, `ram_ce1_n`=1, `ram_ce2`=0, `ram_oe_n`=1, `ram_we_n`=1, `ram_dq_oe`=0 and `rsp_valid`=0.
- R2: A request is accepted only on an edge where `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the accepting edge until the cycle ends, and any request presented during that time has no effect.
- R3: In the cycle after acceptance, the memory is selected (`ram_ce1_n`=0 and `ram_ce2`=1). It stays selected through the last cycle of the access.
- R4: For a read, `ram_addr` holds the accepted address for all 14 selected cycles. `ram_oe_n` is high in selected cycles 1 to 8 and low in cycles 9 to 14.
- R5: `ram_dq_in` is sampled at the edge that ends selected cycle 14 of a read. In the following cycle, `rsp_valid` is 1 for exactly one cycle with that byte on `rsp_rdata`.
- R6: For a write, `ram_we_n` is low in selected cycles 4 to 10 and high otherwise. `ram_dq_oe` is high in exactly those cycles, and `ram_dq_out` carries the accepted byte.
- R7: During write setup (selected cycles 1 to 3), `ram_we_n` is high and the bus is not driven. `ram_oe_n` stays high for the whole write.
- R8: A read is selected for 14 cycles and a write for 14 cycles. Both ceilings are derived from the parameters.
- R9: The controller never drives the bus while `ram_oe_n` is low. It drives only after at least 3 cycles with `ram_oe_n` high, which covers the 15 ns release time.
- R10: After every access there is at least one cycle with the memory deselected and `req_ready`=1, before the next access is selected.
- R11: A read of an address returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| ram_addr | output | 17 | Memory address pins |
| ram_dq_out | output | 8 | Byte to drive onto the data bus |
| ram_dq_oe | output | 1 | Bus drive enable toward the memory |
| ram_dq_in | input | 8 | Byte received from the data bus |
| ram_ce1_n | output | 1 | Active-low memory select |
| ram_ce2 | output | 1 | Active-high memory select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |

## Verification
The bench targets four failure modes, each with a visible symptom.

- **Read right after write, and write right after read.** A controller that skipped the release wait would drive the bus while the memory model still drives it. The model flags that as contention.
- **Shortened phase count.** The memory model returns a junk byte until both the address-hold and output-enable-hold times have elapsed. A controller that cut a phase would therefore capture the wrong data.
- **Requests presented while busy.** A controller that took them would move the address pins or cut the access short.
- **Boundary addresses and random write-then-read traffic.** A dropped or stretched write pulse, or a mistimed data window, would fail the memory model's write checks and the scoreboard comparison.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_OE,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC
  } ctrl_state_e;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sram_pin_ctrl.sv
`timescale 1ns/1ps
module sram_pin_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_e       nxt_state,
  input  logic              latch,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  output logic              ram_ce1_n,
  output logic              ram_ce2,
  output logic              ram_oe_n,
  output logic              ram_we_n
);

  logic sel_nxt, oe_nxt, we_nxt;

  always_comb begin
    sel_nxt = (nxt_state != ST_IDLE);
    oe_nxt  = (nxt_state == ST_RD_OE) || (nxt_state == ST_RD_CAP);
    we_nxt  = (nxt_state == ST_WR_PULSE);
  end

  // strobes registered from the next state so pins switch with the state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_ce1_n <= 1'b1;
      ram_ce2   <= 1'b0;
      ram_oe_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_dq_oe <= 1'b0;
    end else begin
      ram_ce1_n <= !sel_nxt;
      ram_ce2   <= sel_nxt;
      ram_oe_n  <= !oe_nxt;
      ram_we_n  <= !we_nxt;
      ram_dq_oe <= we_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
    end else if (latch) begin
      ram_addr   <= addr_in;
      ram_dq_out <= wdata_in;
    end
  end

  // R6: bus driven only under a write strobe with outputs disabled
  p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n && ram_oe_n));

  // R7: write strobe only while the part is selected
  p_we_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce1_n && ram_ce2));

  // R7: output enable and write enable never low together
  p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_oe_n && !ram_we_n));

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  // R5: response strobe lasts a single cycle
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 25,
  parameter int T_OHZ_NS = 15,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 35,
  parameter int T_AW_NS  = 35,
  parameter int T_DS_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic              ram_ce1_n,
  output logic              ram_ce2,
  output logic              ram_oe_n,
  output logic              ram_we_n
);

  // read: address phase + output-enable phase + one capture cycle
  localparam int RD_OE_CYC   = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int RD_TOT_CYC  = ns_to_cyc(max2(T_RC_NS, T_AA_NS), CLK_NS);
  localparam int RD_ADDR_CYC = max2(1, RD_TOT_CYC - RD_OE_CYC - 1);
  // write: bus release wait, strobe, recovery to full cycle length
  localparam int WR_SETUP_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int WR_PULSE_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                          ns_to_cyc(T_DS_NS, CLK_NS)),
                                     ns_to_cyc(T_AW_NS, CLK_NS) - WR_SETUP_CYC);
  localparam int WR_REC_CYC   = max2(1, ns_to_cyc(T_WC_NS, CLK_NS)
                                        - WR_SETUP_CYC - WR_PULSE_CYC);
  localparam int MAX_CYC = max2(max2(RD_ADDR_CYC, RD_OE_CYC),
                                max2(max2(WR_SETUP_CYC, WR_PULSE_CYC), WR_REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e      state, nxt;
  logic             ph_last, ph_load, accept;
  logic [CNT_W-1:0] ph_len;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (req_valid) nxt = req_write ? ST_WR_SETUP : ST_RD_ADDR;
      ST_RD_ADDR:  if (ph_last) nxt = ST_RD_OE;
      ST_RD_OE:    if (ph_last) nxt = ST_RD_CAP;
      ST_RD_CAP:   nxt = ST_IDLE;
      ST_WR_SETUP: if (ph_last) nxt = ST_WR_PULSE;
      ST_WR_PULSE: if (ph_last) nxt = ST_WR_REC;
      ST_WR_REC:   if (ph_last) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_RD_ADDR:  ph_len = CNT_W'(RD_ADDR_CYC);
      ST_RD_OE:    ph_len = CNT_W'(RD_OE_CYC);
      ST_RD_CAP:   ph_len = CNT_W'(1);
      ST_WR_SETUP: ph_len = CNT_W'(WR_SETUP_CYC);
      ST_WR_PULSE: ph_len = CNT_W'(WR_PULSE_CYC);
      ST_WR_REC:   ph_len = CNT_W'(WR_REC_CYC);
      default:     ph_len = '0;
    endcase
  end

  assign ph_load = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_len),
    .last     (ph_last)
  );

  sram_pin_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt_state  (nxt),
    .latch      (accept),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe),
    .ram_ce1_n  (ram_ce1_n),
    .ram_ce2    (ram_ce2),
    .ram_oe_n   (ram_oe_n),
    .ram_we_n   (ram_we_n)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (state == ST_RD_CAP),
    .dq_in     (ram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // ---- checks guarding pin sequencing ----
  logic [CNT_W-1:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 oe_hi_cnt <= CNT_W'(WR_SETUP_CYC);
    else if (!ram_oe_n)                         oe_hi_cnt <= '0;
    else if (oe_hi_cnt != CNT_W'(WR_SETUP_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  // R9: drive starts only after the release window has elapsed
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (oe_hi_cnt >= CNT_W'(WR_SETUP_CYC)));

  // R10: idle means standby
  p_standby_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce1_n && !ram_ce2));

  // R4: address held while the part stays selected
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce1_n && $past(!ram_ce1_n)) |-> $stable(ram_addr));

  // R3: the two selects always agree
  p_select_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce1_n == !ram_ce2);

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int TOT = 14;          // selected cycles for both kinds
  localparam int OE_FIRST = 9;
  localparam int WE_FIRST = 4;
  localparam int WE_LAST  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ram_dq_oe, ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n;
  logic [DW-1:0] rsp_rdata, ram_dq_out;
  logic [DW-1:0] ram_dq_in = 8'hA5;
  logic [AW-1:0] ram_addr;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in),
    .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] init_byte(int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  // ---------------- reference model (cycle counting) ----------------
  int n;
  bit kind_rd;
  logic [AW-1:0] cur_a;
  logic [DW-1:0] cur_d, cur_exp, exp_rd;
  bit exp_rv;
  logic [7:0] sb_mem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0; exp_rv = 0; kind_rd = 0;
    end else begin
      exp_rv = 0;
      if (n == 0) begin
        if (req_valid) begin
          n = 1; kind_rd = !req_write; cur_a = req_addr; cur_d = req_wdata;
          if (req_write) sb_mem[int'(req_addr)] = req_wdata;
          else cur_exp = sb_mem.exists(int'(req_addr)) ? sb_mem[int'(req_addr)]
                                                       : init_byte(int'(req_addr));
        end
      end else if (n == TOT) begin
        n = 0;
        if (kind_rd) begin exp_rv = 1; exp_rd = cur_exp; end
      end else begin
        n++;
      end
    end
  end

  // ---------------- memory model state ----------------
  logic [7:0] ram_mem [int];
  int a_cnt = 0, oe_cnt = 0, hold = 0, we_cnt = 0, d_cnt = 0;
  bit prev_we_low = 0;
  logic [AW-1:0] last_a = '0, wa = '0;
  logic [DW-1:0] last_d = '0;

  always @(negedge clk) begin
    bit e_sel, e_oe, e_we, sel_m, drv, we_now;
    string tsel;
    // ---- compare pins against the reference ----
    if (rst_n) begin
      e_sel = (n != 0);
      e_oe  = kind_rd && (n >= OE_FIRST);
      e_we  = !kind_rd && (n >= WE_FIRST) && (n <= WE_LAST);
      tsel  = (n == 0) ? "R10 standby" : ((n == TOT) ? "R8 length" : "R3 select");
      chk(req_ready == (n == 0), "R2 ready", req_ready, n == 0);
      chk({ram_ce1_n, ram_ce2} == {!e_sel, e_sel}, tsel, {ram_ce1_n, ram_ce2}, {!e_sel, e_sel});
      chk(ram_oe_n == !e_oe, kind_rd ? "R4 output enable" : "R7 oe high in write", ram_oe_n, !e_oe);
      chk(ram_we_n == !e_we, (n < WE_FIRST) ? "R7 setup" : "R6 write strobe", ram_we_n, !e_we);
      chk(ram_dq_oe == e_we, (n < WE_FIRST) ? "R7 bus idle" : "R6 drive", ram_dq_oe, e_we);
      if (e_sel) chk(ram_addr == cur_a, "R4 address", ram_addr, cur_a);
      if (e_we)  chk(ram_dq_out == cur_d, "R6 write data", ram_dq_out, cur_d);
      chk(rsp_valid == exp_rv, "R5 valid pulse", rsp_valid, exp_rv);
      if (exp_rv) chk(rsp_rdata == exp_rd, "R11 read data", rsp_rdata, exp_rd);
    end
    // ---- behavioural memory ----
    sel_m  = !ram_ce1_n && ram_ce2;
    drv    = (sel_m && !ram_oe_n && ram_we_n) || (hold > 0);
    if (ram_dq_oe) chk(!drv, "R9 bus contention", drv, 0);
    a_cnt  = (sel_m && ram_addr == last_a) ? a_cnt + 1 : (sel_m ? 1 : 0);
    last_a = ram_addr;
    oe_cnt = (sel_m && !ram_oe_n) ? oe_cnt + 1 : 0;
    hold   = (sel_m && !ram_oe_n) ? 3 : ((hold > 0) ? hold - 1 : 0);
    we_now = sel_m && !ram_we_n;
    if (prev_we_low && !we_now) begin
      chk(we_cnt >= 7, "R6 pulse width", we_cnt, 7);
      chk(d_cnt >= 5, "R6 data setup", d_cnt, 5);
      ram_mem[int'(wa)] = last_d;
    end
    if (we_now) begin
      we_cnt++;
      d_cnt  = (ram_dq_oe && prev_we_low && ram_dq_out == last_d) ? d_cnt + 1 : (ram_dq_oe ? 1 : 0);
      last_d = ram_dq_out;
      wa     = ram_addr;
      if (we_cnt == 1) chk(a_cnt >= 1, "R7 address before strobe", a_cnt, 1);
    end else begin
      we_cnt = 0;
    end
    if (prev_we_low && !we_now) chk(1'b1, "R7 end", 0, 0);
    prev_we_low = we_now;
    if (sel_m && !ram_oe_n && ram_we_n && oe_cnt >= 5 && a_cnt >= 14)
      ram_dq_in <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : init_byte(int'(ram_addr));
    else
      ram_dq_in <= 8'hA5;
  end

  // ---------------- stimulus ----------------
  task automatic do_req(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] rnd_byte();
    logic [7:0] b;
    b = 8'($urandom);
    if (b == 8'hA5) b = 8'h5A;
    return b;
  endfunction

  int rnd_addr [24];

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(req_ready == 1 && ram_ce1_n == 1 && ram_ce2 == 0, "R1 reset select", {req_ready, ram_ce1_n, ram_ce2}, 3'b110);
      chk(ram_oe_n == 1 && ram_we_n == 1 && ram_dq_oe == 0, "R1 reset strobes", {ram_oe_n, ram_we_n, ram_dq_oe}, 3'b110);
      chk(rsp_valid == 0, "R1 reset response", rsp_valid, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // boundary addresses
    do_req(1, '0, 8'h11);
    do_req(1, '1, 8'hEE);
    do_req(0, '0, 8'h00);
    do_req(0, '1, 8'h00);
    // write right after read, then read right after write
    do_req(1, 17'd5, 8'h5A);
    do_req(0, 17'd5, 8'h00);
    // R2: requests presented while busy are ignored
    do_req(1, 17'h00ABC, 8'h77);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1F0F0;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    do_req(0, 17'h00ABC, 8'h00);
    // random write-then-read traffic
    for (int i = 0; i < 24; i++) begin
      rnd_addr[i] = int'(17'($urandom));
      do_req(1, 17'(rnd_addr[i]), rnd_byte());
    end
    for (int i = 0; i < 24; i++) do_req(0, 17'(rnd_addr[i]), 8'h00);
    wait_idle();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule